// File: doc/BRIEF.md
# Byte Program-Verify Controller

This block sits on the programmer side of a reprogrammable memory device and writes one byte per request. A request carries a target address and a data byte, and requests may target addresses in any order. For each byte the controller runs a pulse loop. It writes the set-up command, then writes the address with the data, waits a fixed pulse time, and reads the byte back. It repeats this loop until the readback equals the target or the pulse limit is used up.

Programming can only turn bits from 1 to 0. A target of all ones therefore needs no pulse and passes at once. If the readback has a 0 where the target holds a 1, further pulses cannot repair it, so the byte fails straight away. On any failure the controller writes the reset command twice, which returns the device to read mode. It then reports the result. Each result carries pass or fail and the number of pulses applied, and is shown for one cycle together with a done strobe.

Top module: `byte_prog_ctrl`

## Requirements
- R1: After a synchronous active-low reset the controller is idle: `req_ready` is 1, `bus_valid` is 0 and `done` is 0.
- R2: A request whose data is 8'hFF issues no bus cycle and produces `done`=1, `done_pass`=1, `done_pulses`=0 in the cycle right after it is accepted.
- R3: Each pulse starts with a write of 8'h40 (`bus_write`=1) to the target address, followed in the next cycle by a write of the target data to the same address. The first such pair starts in the cycle after acceptance, and requests may use any address order.
- R4: After the data write, `bus_valid` stays 0 for exactly PULSE_CYC cycles. Then one read cycle (`bus_valid`=1, `bus_write`=0) of the target address follows, and `bus_rdata` is sampled in that cycle.
- R5: If the readback equals the target, the next cycle shows `done`=1, `done_pass`=1, and `done_pulses` equal to the pulses applied to this byte.
- R6: If the readback differs only in bits that read 1 where the target is 0, and fewer than MAX_PULSES pulses have been applied, a new set-up write follows in the next cycle.
- R7: If the readback has any bit at 0 where the target is 1, the byte fails after that verify, whatever the pulse count.
- R8: If the readback still differs after MAX_PULSES pulses, the byte fails, with `done_pulses` equal to MAX_PULSES.
- R9: A failing byte gets two consecutive writes of 8'hFF to the target address, starting the cycle after the verify read. The cycle after them shows `done`=1, `done_pass`=0 and the pulse count.
- R10: `req_ready` is 0 from the cycle after acceptance through the done cycle, and 1 again in the cycle after done.
- R11: `done` is high for exactly one cycle per request and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Target byte value |
| bus_valid | output | 1 | A device bus cycle is issued this cycle |
| bus_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_W | Device address of the bus cycle |
| bus_wdata | output | 8 | Write data (command or target byte) |
| bus_rdata | input | 8 | Device read data, sampled during a read cycle |
| done | output | 1 | One-cycle result strobe |
| done_pass | output | 1 | Byte programmed correctly (valid with done) |
| done_pulses | output | PW | Pulses applied to the byte (valid with done) |

## Verification
The results follow a fixed schedule after the accepting clock edge:
- A blank byte reports on the next cycle.
- For a byte that needs programming, the set-up write falls on cycle 1 after acceptance and the data write on cycle 2.
- The verify read follows PULSE_CYC idle cycles after the data write, and each further pulse repeats this pattern.
- The result comes one cycle after the deciding verify, or three cycles after it when the two reset writes are needed.

The bench drives each request at a falling edge. It then steps one falling edge at a time and compares every output against the slot it expects in that schedule. The expected schedule is worked out from the request and from the bench's own device model, whose cells need a set number of pulses to program.

// File: rtl/bpc_pkg.sv
// Shared types and constants for the byte program-verify controller.
package bpc_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_PROG   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_VERIFY = 3'd4,
        ST_RST1   = 3'd5,
        ST_RST2   = 3'd6,
        ST_DONE   = 3'd7
    } bpc_state_e;

    localparam logic [7:0] CMD_SETUP = 8'h40;
    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/bpc_pulse_timer.sv
// Program pulse timer.
// Loaded when the data write is issued; counts down while the controller
// waits. Reports expiry in the last of PULSE_CYC wait cycles.
// Assumes PULSE_CYC >= 1.
module bpc_pulse_timer #(
    parameter int PULSE_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(PULSE_CYC) + 1;
    localparam logic [TW-1:0] LOAD_VAL = TW'(PULSE_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Count down the remaining wait cycles of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/bpc_verify_cmp.sv
// Verify comparator.
// Compares the readback byte with the target. Flags a match, and also flags
// a stuck result: some bit reads 0 where the target wants 1. Programming
// only clears bits, so a stuck result cannot be repaired by more pulses.
module bpc_verify_cmp (
    input  logic [7:0] target,
    input  logic [7:0] readback,
    output logic       match,
    output logic       stuck
);
    // Purely combinational comparison of target and readback.
    always_comb begin
        match = (readback == target);
        stuck = |(~readback & target);
    end
endmodule

// File: rtl/bpc_bus_issue.sv
// Bus cycle decoder.
// Turns the controller state into the device bus cycle for that state:
// set-up command, data write, verify read or reset command. Bus outputs
// are decoded from registered state, so they are stable for the whole cycle.
module bpc_bus_issue
    import bpc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  bpc_state_e        state,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata
);
    // Select the bus cycle type and payload for each state.
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = tgt_addr;
        bus_wdata = 8'h00;
        unique case (state)
            ST_SETUP: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = CMD_SETUP;
            end
            ST_PROG: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = tgt_data;
            end
            ST_VERIFY: begin
                bus_valid = 1'b1;
            end
            ST_RST1, ST_RST2: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = CMD_RESET;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/byte_prog_ctrl.sv
// Byte program-verify controller (top).
// Accepts one address/data request at a time. A blank target passes at once.
// Any other target gets repeated pulses: set-up write, data write, a wait of
// PULSE_CYC cycles, then a verify read. The loop ends on a match, on a stuck
// bit, or when MAX_PULSES pulses have been applied. Failures are followed
// by two reset writes. The result is shown for one cycle with done.
// Assumes the device returns read data in the same cycle as the read.
module byte_prog_ctrl
    import bpc_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PULSE_CYC  = 1250,
    parameter int MAX_PULSES = 25,
    parameter int PW         = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              done_pass,
    output logic [PW-1:0]     done_pulses
);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

    bpc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [PW-1:0]     count_q;
    logic              pass_q;
    logic              accept;
    logic              t_expired;
    logic              v_match;
    logic              v_stuck;
    logic              at_limit;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign at_limit = (count_q == LIMIT);

    bpc_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_PROG),
        .run     (state_q == ST_WAIT),
        .expired (t_expired)
    );

    bpc_verify_cmp u_cmp (
        .target   (data_q),
        .readback (bus_rdata),
        .match    (v_match),
        .stuck    (v_stuck)
    );

    bpc_bus_issue #(.ADDR_W(ADDR_W)) u_bus (
        .state     (state_q),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Next-state selection for the pulse-and-verify sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)
                           state_d = (req_data == BYTE_BLANK) ? ST_DONE : ST_SETUP;
            ST_SETUP:  state_d = ST_PROG;
            ST_PROG:   state_d = ST_WAIT;
            ST_WAIT:   if (t_expired) state_d = ST_VERIFY;
            ST_VERIFY: begin
                if (v_match)                 state_d = ST_DONE;
                else if (v_stuck || at_limit) state_d = ST_RST1;
                else                         state_d = ST_SETUP;
            end
            ST_RST1:   state_d = ST_RST2;
            ST_RST2:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request target when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= 8'h00;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Count pulses applied to the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count_q <= '0;
        else if (accept)             count_q <= '0;
        else if (state_q == ST_PROG) count_q <= count_q + 1'b1;
    end

    // Record the outcome: blank passes on accept, otherwise the verify decides.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pass_q <= 1'b0;
        else if (accept)               pass_q <= (req_data == BYTE_BLANK);
        else if (state_q == ST_VERIFY) pass_q <= v_match;
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign done_pass   = done && pass_q;
    assign done_pulses = done ? count_q : '0;
endmodule

// File: rtl/bpc_checker.sv
// Protocol checker for byte_prog_ctrl, attached with bind.
// Observes only the top-level ports.
module bpc_checker #(
    parameter int ADDR_W     = 17,
    parameter int MAX_PULSES = 25,
    parameter int PW         = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              done,
    input logic              done_pass,
    input logic [PW-1:0]     done_pulses
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !done));

    assert_blank_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_pulses == '0) |-> done_pass);

    assert_read_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> $past(!bus_valid));

    assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_pulses <= PW'(MAX_PULSES)));

    assert_fail_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_pass) |-> $past(bus_valid && bus_write && bus_wdata == 8'hFF));

    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind byte_prog_ctrl bpc_checker #(
    .ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES), .PW(PW)
) u_bpc_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(done), .done_pass(done_pass), .done_pulses(done_pulses)
);

// File: tb/tb_byte_prog_ctrl.sv
// Bench for byte_prog_ctrl: behavioural device model plus cycle-by-cycle
// expected schedule compared at every falling edge.
module tb_byte_prog_ctrl;
    localparam int AW    = 8;
    localparam int PULSE = 6;
    localparam int MAXP  = 25;
    localparam int PW    = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = 8'h00;
    logic bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic done, done_pass;
    logic [PW-1:0] done_pulses;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    byte_prog_ctrl #(.ADDR_W(AW), .PULSE_CYC(PULSE), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .done(done), .done_pass(done_pass),
        .done_pulses(done_pulses)
    );

    // Device model: cells need a per-address number of pulses before they take.
    logic [7:0] mem [0:255];
    int hits [0:255];
    bit armed = 1'b0;

    function automatic int need_of(input int a);
        if (a == 'h77) return 99;
        return 1 + (a % 4);
    endfunction

    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        if (rst_n && bus_valid && bus_write) begin
            if (armed) begin
                hits[bus_addr] = hits[bus_addr] + 1;
                if (hits[bus_addr] >= need_of(int'(bus_addr)))
                    mem[bus_addr] <= mem[bus_addr] & bus_wdata;
                armed = 1'b0;
            end else begin
                armed = (bus_wdata == 8'h40);
            end
        end
    end

    task automatic chk(input string tag, input bit ev, input bit ew, input int ea,
                       input int ed, input bit edn, input bit ep, input int epc,
                       input bit er);
        bit ok;
        ok = (bus_valid == ev) && (done == edn) && (req_ready == er);
        if (ev) ok = ok && (bus_write == ew) && (int'(bus_addr) == ea) &&
                     (!ew || int'(bus_wdata) == ed);
        if (edn) ok = ok && (done_pass == ep) && (int'(done_pulses) == epc);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got v=%0b w=%0b a=%0h d=%0h done=%0b pass=%0b n=%0d rdy=%0b; exp v=%0b w=%0b a=%0h d=%0h done=%0b pass=%0b n=%0d rdy=%0b",
                     tag, bus_valid, bus_write, bus_addr, bus_wdata, done, done_pass,
                     done_pulses, req_ready, ev, ew, ea, ed, edn, ep, epc, er);
        end
    endtask

    // Drive one request and follow its schedule cycle by cycle.
    task automatic run_byte(input int a, input int d);
        int cur, h0, nd, p, pred;
        string ftag;
        cur = int'(mem[a]);
        h0  = hits[a];
        nd  = need_of(a);
        chk("R10 idle before request", 0, 0, 0, 0, 0, 0, 0, 1);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_data  = 8'(d);
        @(negedge clk);
        req_valid = 1'b0;
        if (d == 'hFF) begin
            chk("R2 blank byte passes", 0, 0, 0, 0, 1, 1, 0, 0);
            @(negedge clk);
            return;
        end
        p = 0;
        forever begin
            p++;
            chk(p == 1 ? "R3 set-up write" : "R6 retry set-up write", 1, 1, a, 'h40, 0, 0, 0, 0);
            @(negedge clk);
            chk("R3 data write", 1, 1, a, d, 0, 0, 0, 0);
            @(negedge clk);
            for (int i = 0; i < PULSE; i++) begin
                chk("R4 pulse wait", 0, 0, 0, 0, 0, 0, 0, 0);
                @(negedge clk);
            end
            chk("R4 verify read", 1, 0, a, 0, 0, 0, 0, 0);
            pred = (h0 + p >= nd) ? (cur & d) : cur;
            @(negedge clk);
            if (pred == d) begin
                chk("R5 pass result", 0, 0, 0, 0, 1, 1, p, 0);
                @(negedge clk);
                return;
            end
            if (((~pred) & d & 'hFF) != 0) begin ftag = "R7 stuck bit fail"; break; end
            if (p == MAXP) begin ftag = "R8 pulse limit fail"; break; end
        end
        chk("R9 first reset write", 1, 1, a, 'hFF, 0, 0, 0, 0);
        @(negedge clk);
        chk("R9 second reset write", 1, 1, a, 'hFF, 0, 0, 0, 0);
        @(negedge clk);
        chk(ftag, 0, 0, 0, 0, 1, 0, p, 0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got running, exp finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF;
            hits[i] = 0;
        end
        mem['h5A] = 8'h0F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", 0, 0, 0, 0, 0, 0, 0, 1);
        run_byte('h05, 'hFF);   // R2
        run_byte('h10, 'hA5);   // one pulse (R5)
        run_byte('h33, 'h0F);   // four pulses (R6)
        run_byte('h80, 'h3C);   // random order R3
        run_byte('h02, 'h00);
        run_byte('h41, 'h96);
        run_byte('h10, 'hA5);   // already programmed: passes on first verify
        run_byte('h5A, 'hF0);   // R7
        run_byte('h77, 'h12);   // R8
        run_byte('h21, 'hFF);   // R2 again after failures
        run_byte('h22, 'h7E);
        chk("R10 idle after last result", 0, 0, 0, 0, 0, 0, 0, 1);
        finish_run();
    end
endmodule